// File: doc/BRIEF.md
# Addressable tap shift register

This block is a one-bit-wide serial delay line of sixteen stages. On each active clock edge on which the enable is asserted, it takes in one new bit and moves every stored bit one stage further along. At any time, a four-bit address picks one stage and drives its value onto a read output, so the delay can be changed at run time without any clock edge.

A second output always carries the oldest stage, whatever the address. Several instances can be joined into a longer line by feeding this output into the serial input of the next instance. That joining is done outside the block.

Parameters set three things:
- which clock edge is active;
- whether the enable is active high or active low;
- the contents at power-up.

There is no reset input. The contents change only through shifts, and no global reset clears them.

Top module: `tapsr_top`

## Requirements
- R1: The register holds exactly 16 one-bit stages, numbered 0 to 15. Stage k holds the serial bit accepted k shifts before the most recent one, so stage 0 holds the newest bit.
- R2: On an active clock edge with the enable asserted, `din` is stored into stage 0 and each stage k (k ≥ 1) takes the previous value of stage k-1.
- R3: On an active clock edge with the enable not asserted, no stage changes, whatever the value of `din`.
- R4: `tap_q` equals stage `addr`, where `addr` is read as an unsigned binary number from 0 to 15. It follows a change of `addr` without waiting for a clock edge.
- R5: `last_q` always equals stage 15, for every value of `addr`.
- R6: At power-up, stage i holds bit i of the parameter `INIT`. Bit 15 is therefore the first value seen on `last_q`.
- R7: With `CLK_FALLING` = 0, shifts happen on rising edges of `clk`. With `CLK_FALLING` = 1, they happen only on falling edges, and a rising edge changes nothing.
- R8: With `EN_ACTIVE_LOW` = 0, the enable is asserted when `ce` = 1. With `EN_ACTIVE_LOW` = 1, it is asserted when `ce` = 0.
- R9: The result of a shift is visible on `tap_q` and `last_q` directly after the active edge that performed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the active edge is set by `CLK_FALLING` |
| din | input | 1 | Serial bit written into stage 0 on a shift |
| ce | input | 1 | Shift enable; the active level is set by `EN_ACTIVE_LOW` |
| addr | input | 4 | Selects the stage that drives `tap_q` |
| tap_q | output | 1 | Value of the selected stage |
| last_q | output | 1 | Value of stage 15, the cascade output |

## Verification
A stage holding a wrong bit shows up on `tap_q` as soon as its address is driven, because the read path holds no register. It also shows up on `last_q` after at most fifteen further shifts, when the bit reaches the end of the line. A shift that is dropped or added offsets every later bit by one position. A full address sweep after the affected edge therefore exposes it at once. A wrong edge or enable polarity becomes visible right after the first edge on which the block moves when it should hold, or holds when it should move.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;

    // Default number of stages in one delay line.
    localparam int TAPSR_DEPTH_DFLT = 16;

    // Turn the raw enable pin into "shift now", taking its polarity into account.
    function automatic logic tapsr_shift_req(input logic ce_pin, input bit active_low);
        return active_low ? ~ce_pin : ce_pin;
    endfunction

endpackage

// File: rtl/tapsr_stages.sv
module tapsr_stages #(
    parameter int               DEPTH       = 16,
    parameter logic [DEPTH-1:0] INIT        = '0,
    parameter bit               CLK_FALLING = 1'b0
) (
    input  logic             clk,
    input  logic             din,
    input  logic             shift_en,
    output logic [DEPTH-1:0] stages
);

    // Preset contents; there is deliberately no reset path.
    logic [DEPTH-1:0] bits_q = INIT;
    logic [DEPTH-1:0] bits_d;

    always_comb begin
        bits_d = bits_q;
        if (shift_en) begin
            bits_d = {bits_q[DEPTH-2:0], din};
        end
    end

    generate
        if (CLK_FALLING) begin : g_fall
            always_ff @(negedge clk) begin
                bits_q <= bits_d;
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                bits_q <= bits_d;
            end
        end
    endgenerate

    assign stages = bits_q;

endmodule

// File: rtl/tapsr_tap_mux.sv
module tapsr_tap_mux #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]  stages,
    input  logic [ADDR_W-1:0] addr,
    output logic              tap
);

    // Purely combinational selection; an address that is out of range reads 0.
    always_comb begin
        tap = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == ADDR_W'(i)) begin
                tap = stages[i];
            end
        end
    end

endmodule

// File: rtl/tapsr_top.sv
module tapsr_top #(
    parameter int               DEPTH         = tapsr_pkg::TAPSR_DEPTH_DFLT,
    parameter logic [DEPTH-1:0] INIT          = '0,
    parameter bit               CLK_FALLING   = 1'b0,
    parameter bit               EN_ACTIVE_LOW = 1'b0,
    localparam int              ADDR_W        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              din,
    input  logic              ce,
    input  logic [ADDR_W-1:0] addr,
    output logic              tap_q,
    output logic              last_q
);

    logic             shift_en;
    logic [DEPTH-1:0] stage_vec;

    assign shift_en = tapsr_pkg::tapsr_shift_req(ce, EN_ACTIVE_LOW);

    tapsr_stages #(
        .DEPTH       (DEPTH),
        .INIT        (INIT),
        .CLK_FALLING (CLK_FALLING)
    ) stages_i (
        .clk      (clk),
        .din      (din),
        .shift_en (shift_en),
        .stages   (stage_vec)
    );

    tapsr_tap_mux #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) mux_i (
        .stages (stage_vec),
        .addr   (addr),
        .tap    (tap_q)
    );

    // Cascade output: the oldest stage, never routed through the address mux.
    assign last_q = stage_vec[DEPTH-1];

endmodule

// File: rtl/tapsr_checker.sv
module tapsr_checker #(
    parameter int               DEPTH         = 16,
    parameter logic [DEPTH-1:0] INIT          = '0,
    parameter bit               CLK_FALLING   = 1'b0,
    parameter bit               EN_ACTIVE_LOW = 1'b0,
    parameter int               ADDR_W        = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              din,
    input logic              ce,
    input logic [ADDR_W-1:0] addr,
    input logic              tap_q,
    input logic              last_q,
    input logic [DEPTH-1:0]  stages
);

    logic act_clk;
    logic en_chk;
    logic seen = 1'b0;

    assign act_clk = CLK_FALLING ? ~clk : clk;
    assign en_chk  = EN_ACTIVE_LOW ? ~ce : ce;

    always_ff @(posedge act_clk) begin
        seen <= 1'b1;
    end

    // R6: power-up contents come from INIT.
    a_r6_init_contents: assert property (@(posedge act_clk)
        !seen |-> stages == INIT);

    // R2: the enabled edge moves every stage up by one and takes in din.
    a_r2_shift_moves: assert property (@(posedge act_clk) disable iff (!seen)
        en_chk |=> stages == {$past(stages[DEPTH-2:0]), $past(din)});

    // R3: a disabled edge holds every stage.
    a_r3_hold_all: assert property (@(posedge act_clk) disable iff (!seen)
        !en_chk |=> $stable(stages));

    // R5: the cascade output takes the old next-to-last stage on a shift.
    a_r5_cascade_moves: assert property (@(posedge act_clk) disable iff (!seen)
        en_chk |=> last_q == $past(stages[DEPTH-2]));

    // R4: with no shift and no address change, the tap does not move.
    a_r4_tap_steady: assert property (@(posedge act_clk) disable iff (!seen)
        !en_chk |=> (!$stable(addr) || $stable(tap_q)));

endmodule

bind tapsr_top tapsr_checker #(
    .DEPTH         (DEPTH),
    .INIT          (INIT),
    .CLK_FALLING   (CLK_FALLING),
    .EN_ACTIVE_LOW (EN_ACTIVE_LOW),
    .ADDR_W        (ADDR_W)
) chk_i (
    .clk    (clk),
    .din    (din),
    .ce     (ce),
    .addr   (addr),
    .tap_q  (tap_q),
    .last_q (last_q),
    .stages (stage_vec)
);

// File: tb/tapsr_top_tb_top.sv
`timescale 1ns/10ps
module tapsr_top_tb_top;

    localparam logic [15:0] INIT_A = 16'hA5C3;
    localparam logic [15:0] INIT_B = 16'h3C96;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    // Instance A: rising edge, active-high enable.
    logic       din_a = 1'b0, ce_a = 1'b0;
    logic [3:0] addr_a = 4'd0;
    logic       tap_a, last_a;

    // Instance B: falling edge, active-low enable (ce_b = 1 means hold).
    logic       din_b = 1'b0, ce_b = 1'b1;
    logic [3:0] addr_b = 4'd0;
    logic       tap_b, last_b;

    tapsr_top #(.INIT(INIT_A)) dut_i (
        .clk(clk), .din(din_a), .ce(ce_a), .addr(addr_a), .tap_q(tap_a), .last_q(last_a)
    );

    tapsr_top #(.INIT(INIT_B), .CLK_FALLING(1'b1), .EN_ACTIVE_LOW(1'b1)) dut_n_i (
        .clk(clk), .din(din_b), .ce(ce_b), .addr(addr_b), .tap_q(tap_b), .last_q(last_b)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [15:0] ma = INIT_A;
    logic [15:0] mb = INIT_B;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // R4/R5: walk the address between edges; the tap follows at once and the cascade never moves.
    task automatic sweep_a(input string req);
        for (int a = 0; a < 16; a++) begin
            addr_a = 4'(a);
            #0.05;
            chk({req, " R4 tap A"}, tap_a, ma[a]);
            chk({req, " R5 cascade A"}, last_a, ma[15]);
        end
    endtask

    task automatic sweep_b(input string req);
        for (int a = 0; a < 16; a++) begin
            addr_b = 4'(a);
            #0.05;
            chk({req, " R4 tap B"}, tap_b, mb[a]);
            chk({req, " R5 cascade B"}, last_b, mb[15]);
        end
    endtask

    function automatic logic [15:0] next_lfsr(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // One rising-edge step of A; inputs change at the falling edge.
    task automatic step_a(input logic d, input logic c, input string req);
        @(negedge clk);
        din_a  = d;
        ce_a   = c;
        addr_a = 4'd0;
        @(posedge clk);
        #0.5;
        if (c) ma = {ma[14:0], d};
        chk("R9 tap A right after edge", tap_a, ma[0]);
        chk("R9 cascade A right after edge", last_a, ma[15]);
        sweep_a(req);
    endtask

    // One falling-edge step of B, with a check that the rising edge in between changes nothing.
    task automatic step_b(input logic d, input logic c_pin, input string req);
        @(posedge clk);
        #0.3;
        chk("R7 B steady across rising edge cascade", last_b, mb[15]);
        chk("R7 B steady across rising edge tap", tap_b, mb[addr_b]);
        din_b  = d;
        ce_b   = c_pin;
        @(negedge clk);
        #0.5;
        if (!c_pin) mb = {mb[14:0], d};
        sweep_b(req);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R6: power-up contents, before any clock edge.
        #0.5;
        sweep_a("R6 init");
        sweep_b("R6 init");
        chk("R6 first cascade A = INIT bit 15", last_a, INIT_A[15]);
        chk("R6 first cascade B = INIT bit 15", last_b, INIT_B[15]);

        // R1/R2: fill A completely with a known walking pattern, stage k = bit k shifts ago.
        for (int i = 0; i < 16; i++) step_a(logic'(i % 3 == 0), 1'b1, "R1 R2 fill");
        for (int i = 0; i < 16; i++) step_a(logic'(i == 15), 1'b1, "R1 R2 single one");

        // R3: enable off, din toggling.
        for (int i = 0; i < 8; i++) step_a(logic'(i[0]), 1'b0, "R3 hold");

        // R2/R3 mixed: pseudo-random data and enable.
        for (int i = 0; i < 64; i++) begin
            lfsr = next_lfsr(lfsr);
            step_a(lfsr[0], lfsr[3] | lfsr[7], "R2 R3 random");
        end

        // R7/R8: B shifts on falling edges only, and only while ce is low.
        for (int i = 0; i < 16; i++) step_b(logic'(i[1]), 1'b0, "R7 R8 shift");
        for (int i = 0; i < 6; i++) step_b(logic'(~i[0]), 1'b1, "R8 hold on ce high");
        for (int i = 0; i < 40; i++) begin
            lfsr = next_lfsr(lfsr);
            step_b(lfsr[2], lfsr[5] & lfsr[9], "R7 R8 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule